// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees a two-wire bus that a target device has left hung by holding the data line low, typically because the target was in the middle of returning a read byte when the controller lost track of the transfer. On a single-cycle request the sequencer checks the data line first. If the line is low, it toggles the clock line through open-drain outputs and leaves data released, so the target can shift out what remains of its byte and then sees a not-acknowledge in the acknowledge slot.

The data line is sampled in the middle of every clock-high phase. As soon as it reads high, pulsing stops and the block forms a STOP condition, then reports success. If the line is still low after nine pulses, which covers eight data bits plus the acknowledge slot, the block releases both lines and reports failure. The clock phases run off a programmable half-period divider. A target that holds the clock low is waited on, and a programmable timeout aborts the recovery.

Top module: `bus_unhang_seq`

## Requirements
- R1: After reset and whenever idle, busy_o, done_o and fail_o are 0 and both scl_drive_low_o and sda_drive_low_o are 0 (lines released).
- R2: A request that finds SDA high skips pulsing. The block issues only the STOP sequence (SCL driven low for two half periods, one rising SCL edge) and then pulses done_o.
- R3: With SDA low at request, each recovery pulse drives SCL low for exactly half_period_i system clocks, then releases it for half_period_i clocks counted from the moment SCL reads high.
- R4: SDA is sampled at the middle of each SCL-high phase. After the first pulse in which it reads high, pulsing stops and a STOP follows, so a target that lets go after k falling SCL edges (1 ≤ k ≤ 9) yields k+1 SCL rising edges and done_o.
- R5: The budget is 9 pulses. If SDA is still low after the ninth pulse, both lines are released, fail_o pulses, and exactly 9 SCL rising edges have been produced.
- R6: The block asserts sda_drive_low_o only while it has driven SCL low since at least the previous cycle. The only SDA rise while SCL is high is the single STOP edge of a successful recovery.
- R7: While SCL is released but reads low (clock stretching), the high-phase timer holds. Recovery resumes when SCL rises and still completes with the normal edge count.
- R8: If SCL reads low for stretch_limit_i consecutive clocks while released, the block aborts: fail_o pulses and both lines are released.
- R9: A request while busy_o is 1 is ignored. Each accepted request produces exactly one done_o or fail_o pulse.
- R10: done_o and fail_o last one cycle each and never assert together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Single-cycle recovery request |
| half_period_i | input | DIV_W | SCL half period in system clocks (≥ 1) |
| stretch_limit_i | input | TO_W | Clocks of SCL held low before abort |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_drive_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | Recovery in progress |
| done_o | output | 1 | One-cycle success pulse |
| fail_o | output | 1 | One-cycle failure pulse |

## Verification
The bench builds the block with a pulse budget of 9, two synchronizer stages and 8-bit divider and timeout widths. It drives half periods of 3, 4, 5 and 7 clocks at run time with a stretch limit of 64. The short half periods keep each nine-pulse budget to a few hundred cycles, so the bench can sweep every target release point from zero to beyond the budget, including the ninth-pulse boundary. The 64-clock limit lets a 40-clock stretch pass and a permanent stretch abort in the same run.

// File: rtl/unhang_pkg.sv
package unhang_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE_LO,
    ST_PULSE_HI,
    ST_STOP_SCL,
    ST_STOP_SDA,
    ST_STOP_HI
  } state_e;
endpackage

// File: rtl/unhang_sync.sv
module unhang_sync #(
  parameter int  STAGES    = 2,
  parameter bit  RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q_o = d_i;
    end else begin : g_flops
      logic [STAGES-1:0] sr_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= {STAGES{RESET_VAL}};
        else if (STAGES == 1) sr_q <= d_i;
        else sr_q <= {sr_q[STAGES-2:0], d_i};
      end
      assign q_o = sr_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/unhang_phase_timer.sv
module unhang_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] half_i,
  output logic         mid_o,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  assign last_o = en_i && (cnt_q == half_i - W'(1));
  assign mid_o  = en_i && (cnt_q == (half_i >> 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i || last_o) cnt_q <= '0;
    else if (en_i)           cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/unhang_stretch_wdt.sv
module unhang_stretch_wdt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         watch_i,
  input  logic [W-1:0] limit_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  assign expired_o = watch_i && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!watch_i)        cnt_q <= '0;
    else if (cnt_q != limit_i) cnt_q <= cnt_q + W'(1);
  end

  assert_wdt_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !watch_i |=> !expired_o);
endmodule

// File: rtl/bus_unhang_seq.sv
module bus_unhang_seq
  import unhang_pkg::*;
#(
  parameter int PULSES      = 9,
  parameter int DIV_W       = 8,
  parameter int TO_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [DIV_W-1:0] half_period_i,
  input  logic [TO_W-1:0]  stretch_limit_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_drive_low_o,
  output logic             sda_drive_low_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o
);
  localparam int PC_W = $clog2(PULSES + 1);

  state_e          state_q, state_d;
  logic [PC_W-1:0] pulse_q, pulse_d;
  logic            seen_q, seen_d;
  logic            done_d, fail_d;
  logic            scl_s, sda_s;
  logic            scl_rel, t_en, t_clr, t_mid, t_last, wdt_exp;

  unhang_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_scl_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(scl_i), .q_o(scl_s));
  unhang_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sda_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sda_i), .q_o(sda_s));

  // SCL released by us: timer advances only once the line reads high
  assign scl_rel = (state_q == ST_PULSE_HI) || (state_q == ST_STOP_HI);
  assign t_clr   = (state_q == ST_IDLE);
  assign t_en    = !t_clr && (!scl_rel || scl_s);

  unhang_phase_timer #(.W(DIV_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(t_clr), .en_i(t_en),
    .half_i(half_period_i), .mid_o(t_mid), .last_o(t_last));

  unhang_stretch_wdt #(.W(TO_W)) u_wdt (
    .clk_i(clk_i), .rst_ni(rst_ni), .watch_i(scl_rel && !scl_s),
    .limit_i(stretch_limit_i), .expired_o(wdt_exp));

  always_comb begin
    state_d = state_q;
    pulse_d = pulse_q;
    seen_d  = seen_q;
    done_d  = 1'b0;
    fail_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        pulse_d = '0;
        seen_d  = 1'b0;
        if (req_i) state_d = sda_s ? ST_STOP_SCL : ST_PULSE_LO;
      end
      ST_PULSE_LO: begin
        seen_d = 1'b0;
        if (t_last) state_d = ST_PULSE_HI;
      end
      ST_PULSE_HI: begin
        if (t_mid && sda_s) seen_d = 1'b1;
        if (wdt_exp) begin
          state_d = ST_IDLE;
          fail_d  = 1'b1;
        end else if (t_last) begin
          if (seen_q || (t_mid && sda_s)) begin
            state_d = ST_STOP_SCL;
          end else if (pulse_q == PC_W'(PULSES - 1)) begin
            state_d = ST_IDLE;
            fail_d  = 1'b1;
          end else begin
            pulse_d = pulse_q + PC_W'(1);
            state_d = ST_PULSE_LO;
          end
        end
      end
      ST_STOP_SCL: if (t_last) state_d = ST_STOP_SDA;
      ST_STOP_SDA: if (t_last) state_d = ST_STOP_HI;
      ST_STOP_HI: begin
        if (wdt_exp) begin
          state_d = ST_IDLE;
          fail_d  = 1'b1;
        end else if (t_last) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pulse_q <= '0;
      seen_q  <= 1'b0;
      done_o  <= 1'b0;
      fail_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= pulse_d;
      seen_q  <= seen_d;
      done_o  <= done_d;
      fail_o  <= fail_d;
    end
  end

  assign busy_o          = (state_q != ST_IDLE);
  assign scl_drive_low_o = (state_q == ST_PULSE_LO) || (state_q == ST_STOP_SCL) ||
                           (state_q == ST_STOP_SDA);
  assign sda_drive_low_o = (state_q == ST_STOP_SDA) || (state_q == ST_STOP_HI);

  assert_idle_released_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!scl_drive_low_o && !sda_drive_low_o));

  assert_skip_to_stop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && req_i && sda_s) |=> (state_q == ST_STOP_SCL));

  assert_budget_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_q <= PC_W'(PULSES - 1)));

  assert_sda_under_scl_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_drive_low_o) |-> (scl_drive_low_o && $past(scl_drive_low_o)));

  assert_sda_release_is_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sda_drive_low_o) && !fail_o) |-> done_o);

  assert_fail_releases_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (!scl_drive_low_o && !sda_drive_low_o));

  assert_busy_ignores_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_d && !fail_d) |=> busy_o);

  assert_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));

  assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_fail_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> !fail_o);
endmodule

// File: tb/bus_unhang_seq_bench.sv
module bus_unhang_seq_bench;
  localparam int DIV_W = 8;
  localparam int TO_W  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [DIV_W-1:0] half = 8'd4;
  logic [TO_W-1:0]  limit = 8'd64;
  logic scl_drv, sda_drv, busy, done, fail;
  logic stretch = 1'b0;
  int   hold = 0;
  logic scl_line, sda_line;

  assign scl_line = !(scl_drv || stretch);
  assign sda_line = !(sda_drv || (hold > 0));

  always #2.5 clk = ~clk;

  bus_unhang_seq #(.PULSES(9), .DIV_W(DIV_W), .TO_W(TO_W), .SYNC_STAGES(2)) u_bus_unhang_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .half_period_i(half),
    .stretch_limit_i(limit), .scl_i(scl_line), .sda_i(sda_line),
    .scl_drive_low_o(scl_drv), .sda_drive_low_o(sda_drv),
    .busy_o(busy), .done_o(done), .fail_o(fail));

  // target model: releases SDA after 'hold' falling SCL edges
  always @(negedge scl_line) if (hold > 0) hold = hold - 1;

  typedef struct {
    bit    ok;
    int    rises;
    int    low_w;
    int    stops;
    string tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0, results = 0;

  task automatic check(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor
  logic prev_scl = 1'b1, prev_sda = 1'b1, prev_res = 1'b0;
  int   rises = 0, stops = 0, illegal = 0, low_cnt = 0, low_w = -1;
  bit   low_started = 0, low_done = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_res) check(!(done || fail), "R10 pulse width", int'(done || fail), 0);
      if (busy || done || fail) begin
        if (prev_scl && !scl_line && !low_started) low_started = 1;
        if (low_started && !low_done && !scl_line) low_cnt++;
        if (!prev_scl && scl_line) begin
          rises++;
          if (low_started && !low_done) begin low_done = 1; low_w = low_cnt; end
        end
        if (prev_scl && scl_line && !prev_sda && sda_line) stops++;
        if (prev_scl && scl_line && prev_sda && !sda_line) illegal++;
      end
      if (done || fail) begin
        check(!(done && fail), "R10 exclusive", int'(done && fail), 0);
        if (q.size() == 0) begin
          check(0, "R9 unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(done == e.ok, e.tag, int'(done), int'(e.ok));
          check(rises == e.rises, "R4/R5 scl rises", rises, e.rises);
          if (e.low_w >= 0) check(low_w == e.low_w, "R3 low phase", low_w, e.low_w);
          check(stops == e.stops, "R6 stop count", stops, e.stops);
          check(illegal == 0, "R6 sda fall with scl high", illegal, 0);
        end
        results++;
        rises = 0; stops = 0; illegal = 0; low_cnt = 0; low_w = -1;
        low_started = 0; low_done = 0;
      end
    end
    prev_res = done || fail;
    prev_scl = scl_line;
    prev_sda = sda_line;
  end

  // driver; stretch_mode: 0 none, 1 short (40 clocks), 2 permanent
  task automatic run_op(input int k, input int n, input int stretch_mode,
                        input bit extra_req, input string tag);
    exp_t e;
    int   want;
    half = DIV_W'(n);
    hold = k;
    repeat (10) @(negedge clk);
    e.tag = tag;
    if (stretch_mode == 2) begin
      e.ok = 0; e.rises = 0; e.low_w = -1; e.stops = 0;
    end else if (k == 0) begin
      e.ok = 1; e.rises = 1; e.low_w = 2 * n; e.stops = 1;
    end else if (k <= 9) begin
      e.ok = 1; e.rises = k + 1; e.low_w = (stretch_mode == 1) ? -1 : n; e.stops = 1;
    end else begin
      e.ok = 0; e.rises = 9; e.low_w = n; e.stops = 0;
    end
    q.push_back(e);
    want = results + 1;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    fork
      begin
        if (stretch_mode != 0) begin
          wait (scl_drv == 1'b1);
          @(negedge clk);
          stretch = 1'b1;
          if (stretch_mode == 1) begin
            repeat (40) @(negedge clk);
            stretch = 1'b0;
          end
        end
      end
      begin
        if (extra_req) begin
          repeat (10) @(negedge clk);
          req = 1'b1;
          @(negedge clk);
          req = 1'b0;
        end
      end
    join
    wait (results == want);
    repeat (5) @(negedge clk);
    if (extra_req) check(!busy, "R9 request while busy ignored", int'(busy), 0);
    stretch = 1'b0;
    hold = 0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !fail, "R1 reset status", int'(busy || done || fail), 0);
    check(!scl_drv && !sda_drv, "R1 reset lines", int'(scl_drv || sda_drv), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!scl_drv && !sda_drv && !busy, "R1 idle after reset", int'(scl_drv || sda_drv || busy), 0);

    run_op(0,  4, 0, 0, "R2 skip to stop");
    run_op(1,  4, 0, 0, "R4 release after 1");
    run_op(3,  7, 0, 0, "R3 half period 7");
    run_op(8,  4, 0, 0, "R4 release after 8");
    run_op(9,  5, 0, 0, "R5 ninth pulse success");
    run_op(10, 4, 0, 0, "R5 budget exhausted");
    run_op(12, 3, 0, 0, "R5 deep hang");
    run_op(2,  4, 1, 0, "R7 short stretch");
    run_op(5,  4, 2, 0, "R8 stretch timeout");
    run_op(4,  4, 0, 1, "R9 busy request");
    run_op(0,  5, 0, 0, "R2 skip again");

    check(q.size() == 0, "R9 pending results", q.size(), 0);
    check(!scl_drv && !sda_drv && !busy, "R1 final idle", int'(scl_drv || sda_drv || busy), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", results, 11);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule